// File: doc/BRIEF.md
# Pulse-swallow dual-modulus feedback divider

This block produces the two comparison pulses of a frequency synthesizer loop. On the fast side, a dual-modulus prescaler divides the oscillator-rate clock by either P or P+1. A swallow counter and a main counter steer the prescaler so that one output period is exactly P·N + A fast clock cycles long. The prescaler runs at P+1 for the first A prescaler cycles of a period and at P for the rest, until N prescaler cycles have passed. On the slow side, a binary counter divides the reference clock by R. The synthesized frequency is therefore (P·N + A)·f_ref / R.

The divide settings arrive already latched. Each counter chain takes a new setting only at the end of a complete period. Changing a setting while a period is running therefore never produces a truncated or stretched period. A setting that breaks the rule A < N is treated as A = N−1, and a flag is raised while that setting is in use.

Top module: `pswallow_div`

## Requirements
- R1: `fp` is high for exactly one `clk_vco` cycle once every P·N + A cycles of `clk_vco`. Within each period the prescaler divides by P+1 for the first A prescaler cycles and by P for the remaining N−A.
- R2: `narrow_sel` = 1 selects P = 32; `narrow_sel` = 0 selects P = 64.
- R3: With `a_set` = 0 the period is exactly P·N cycles: the prescaler never divides by P+1.
- R4: `fr` is high for exactly one `clk_ref` cycle once every R cycles of `clk_ref`, for any R from 8 to 16383.
- R5: `n_set`, `a_set` and `narrow_sel` are sampled only at the `clk_vco` edge that raises `fp`, and at every `clk_vco` edge while `rst_n` is low. Changing them at any other time leaves the length of the running period unchanged.
- R6: `r_set` is sampled only at the `clk_ref` edge that raises `fr`, and at every `clk_ref` edge while `rst_n` is low. Changing it mid-period leaves the running reference period unchanged.
- R7: When the sampled `a_set` is greater than or equal to `n_set`, the period is P·N + N − 1 cycles. `ratio_clamp` is high for exactly the periods that run on such a setting and low for all other periods.
- R8: While `rst_n` is low at a clock edge, `fp` and `fr` are driven low and both counter chains restart. The first `fp` is high in the cycle after the (P·N + A)-th `clk_vco` rising edge after reset is released. The first `fr` is high in the cycle after the R-th `clk_ref` rising edge after reset is released.
- R9: The full setting range is supported: N from 16 to 2047 and A from 0 to 63, including N = 2047 with A = 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Oscillator-rate clock that is divided |
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both clock domains |
| n_set | input | 11 | Main counter setting N |
| a_set | input | 7 | Swallow counter setting A |
| narrow_sel | input | 1 | Prescaler modulus: 1 gives P = 32, 0 gives P = 64 |
| r_set | input | 14 | Reference divide ratio R |
| fp | output | 1 | One-cycle pulse per completed feedback period (`clk_vco` domain) |
| fr | output | 1 | One-cycle pulse per completed reference period (`clk_ref` domain) |
| ratio_clamp | output | 1 | High while the running feedback period uses a setting with A not below N |

## Verification
The feedback chain is tried with several kinds of setting. A nonzero A under each modulus shows that the P+1 cycles are counted exactly A times and that P is selected correctly. A = 0 separates correct handling of an empty swallow phase from an off-by-one extra cycle. Settings with A equal to N and above N check the clamp and the flag. The largest N with the largest A checks the full counter widths.

Settings are also changed repeatedly at arbitrary mid-period points. This shows that new values take effect only on a period boundary. The reference chain is run at the minimum ratio, at an odd ratio, at the maximum ratio, and with changes applied mid-period.

// File: rtl/pswallow_pkg.sv
// Shared defaults and types for the pulse-swallow feedback divider.
package pswallow_pkg;
    localparam int N_W_DEF      = 11;
    localparam int A_W_DEF      = 7;
    localparam int R_W_DEF      = 14;
    localparam int P_NARROW_DEF = 32;
    localparam int P_WIDE_DEF   = 64;

    // Prescaler modulus selection; the encoding matches the narrow_sel pin.
    typedef enum logic {
        MOD_WIDE   = 1'b0,
        MOD_NARROW = 1'b1
    } mod_sel_e;
endpackage

// File: rtl/dm_prescaler.sv
// Dual-modulus prescaler.
// Divides clk by P_NARROW or P_WIDE, plus one extra cycle when 'extra' is high.
// 'tick' is high in the last clock of each prescaler cycle.
// Assumes mod_sel and extra change only in a cycle where tick is high,
// or where the count is restarting.
module dm_prescaler
    import pswallow_pkg::*;
#(
    parameter int P_NARROW = P_NARROW_DEF,
    parameter int P_WIDE   = P_WIDE_DEF
) (
    input  logic     clk,
    input  logic     rst_n,
    input  mod_sel_e mod_sel,
    input  logic     extra,
    output logic     tick
);
    localparam int CW = $clog2(P_WIDE + 2);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // Terminal count of the current prescaler cycle.
    always_comb begin
        last = ((mod_sel == MOD_NARROW) ? CW'(P_NARROW - 1) : CW'(P_WIDE - 1))
             + {{(CW-1){1'b0}}, extra};
        tick = (cnt == last);
    end

    // Cycle counter that wraps at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/swallow_ctrl.sv
// Swallow and main counters.
// Requests the extra prescaler cycle for the first a_act prescaler cycles,
// then ends the period after n_act prescaler cycles.
// Assumes a_act < n_act and n_act >= 2.
module swallow_ctrl #(
    parameter int N_W = pswallow_pkg::N_W_DEF,
    parameter int A_W = pswallow_pkg::A_W_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [N_W-1:0] n_act,
    input  logic [A_W-1:0] a_act,
    output logic           extra,
    output logic           period_end
);
    logic [N_W-1:0] main_cnt;
    logic [A_W-1:0] sw_cnt;

    // Modulus request and end-of-period detection.
    always_comb begin
        extra      = (sw_cnt < a_act);
        period_end = tick && (main_cnt == (n_act - N_W'(1)));
    end

    // Count prescaler cycles; both counters restart at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n || period_end) begin
            main_cnt <= '0;
            sw_cnt   <= '0;
        end else if (tick) begin
            main_cnt <= main_cnt + 1'b1;
            if (extra) begin
                sw_cnt <= sw_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ref_divider.sv
// Reference divider.
// Divides clk by r_set and emits a one-cycle pulse per period.
// r_set is taken at reset and at each period end. Assumes r_set >= 2.
module ref_divider #(
    parameter int R_W = pswallow_pkg::R_W_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [R_W-1:0] r_set,
    output logic [R_W-1:0] r_act,
    output logic           pulse
);
    logic [R_W-1:0] cnt;
    logic           wrap;

    // Last cycle of the current reference period.
    always_comb wrap = (cnt == (r_act - R_W'(1)));

    // Count, reload the ratio at the boundary and drive the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            r_act <= r_set;
            pulse <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            r_act <= r_set;
            pulse <= 1'b1;
        end else begin
            cnt   <= cnt + 1'b1;
            pulse <= 1'b0;
        end
    end
endmodule

// File: rtl/pswallow_div.sv
// Pulse-swallow feedback divider with reference divider (top level).
// The fast chain divides clk_vco by P*N+A; the slow chain divides clk_ref by R.
// Settings are shadowed and take effect only on period boundaries.
// A setting of A >= N is run as A = N-1 and flagged on ratio_clamp.
// Assumes N_W > A_W, N >= 2 and R >= 2.
module pswallow_div
    import pswallow_pkg::*;
#(
    parameter int N_W      = N_W_DEF,
    parameter int A_W      = A_W_DEF,
    parameter int R_W      = R_W_DEF,
    parameter int P_NARROW = P_NARROW_DEF,
    parameter int P_WIDE   = P_WIDE_DEF
) (
    input  logic           clk_vco,
    input  logic           clk_ref,
    input  logic           rst_n,
    input  logic [N_W-1:0] n_set,
    input  logic [A_W-1:0] a_set,
    input  logic           narrow_sel,
    input  logic [R_W-1:0] r_set,
    output logic           fp,
    output logic           fr,
    output logic           ratio_clamp
);
    localparam int PAD_W = N_W - A_W;

    logic [N_W-1:0] n_act;
    logic [A_W-1:0] a_act;
    logic [A_W-1:0] a_fix;
    logic           clamp_now;
    mod_sel_e       sel_act;
    logic           tick;
    logic           extra;
    logic           period_end;
    logic [R_W-1:0] r_act;

    // Apply the A < N rule to the incoming setting.
    always_comb begin
        clamp_now = ({{PAD_W{1'b0}}, a_set} >= n_set);
        a_fix     = clamp_now ? A_W'(n_set - N_W'(1)) : a_set;
    end

    // Shadow the feedback settings at reset and at each period end.
    always_ff @(posedge clk_vco) begin
        if (!rst_n || period_end) begin
            n_act       <= n_set;
            a_act       <= a_fix;
            sel_act     <= mod_sel_e'(narrow_sel);
            ratio_clamp <= clamp_now;
        end
    end

    // One-cycle feedback pulse after each completed period.
    always_ff @(posedge clk_vco) begin
        if (!rst_n) begin
            fp <= 1'b0;
        end else begin
            fp <= period_end;
        end
    end

    dm_prescaler #(
        .P_NARROW (P_NARROW),
        .P_WIDE   (P_WIDE)
    ) u_pre (
        .clk     (clk_vco),
        .rst_n   (rst_n),
        .mod_sel (sel_act),
        .extra   (extra),
        .tick    (tick)
    );

    swallow_ctrl #(
        .N_W (N_W),
        .A_W (A_W)
    ) u_ctrl (
        .clk        (clk_vco),
        .rst_n      (rst_n),
        .tick       (tick),
        .n_act      (n_act),
        .a_act      (a_act),
        .extra      (extra),
        .period_end (period_end)
    );

    ref_divider #(
        .R_W (R_W)
    ) u_ref (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .r_set (r_set),
        .r_act (r_act),
        .pulse (fr)
    );
endmodule

// File: rtl/pswallow_div_chk.sv
// Assertion checker for pswallow_div, attached with bind below.
module pswallow_div_chk #(
    parameter int N_W = pswallow_pkg::N_W_DEF,
    parameter int A_W = pswallow_pkg::A_W_DEF,
    parameter int R_W = pswallow_pkg::R_W_DEF
) (
    input logic           clk_vco,
    input logic           clk_ref,
    input logic           rst_n,
    input logic           fp,
    input logic           fr,
    input logic           period_end,
    input logic [N_W-1:0] n_act,
    input logic [A_W-1:0] a_act,
    input logic           sel_act,
    input logic [R_W-1:0] r_act
);
    // R1: the feedback pulse never lasts more than one cycle.
    assert_fp_single_R1: assert property (@(posedge clk_vco) disable iff (!rst_n)
        fp |=> !fp);

    // R4: the reference pulse never lasts more than one cycle.
    assert_fr_single_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        fr |=> !fr);

    // R5: the active feedback settings change only at a period end.
    assert_cfg_hold_R5: assert property (@(posedge clk_vco) disable iff (!rst_n)
        !period_end |=> $stable({n_act, a_act, sel_act}));

    // R6: the active reference ratio changes only together with the pulse.
    assert_ratio_hold_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ($past(rst_n) && !$stable(r_act)) |-> fr);

    // R7: the running swallow setting is always below the main setting.
    assert_a_below_n_R7: assert property (@(posedge clk_vco) disable iff (!rst_n)
        (n_act != '0) |-> ({{(N_W-A_W){1'b0}}, a_act} < n_act));
endmodule

bind pswallow_div pswallow_div_chk #(
    .N_W (N_W),
    .A_W (A_W),
    .R_W (R_W)
) u_chk (
    .clk_vco    (clk_vco),
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .fp         (fp),
    .fr         (fr),
    .period_end (period_end),
    .n_act      (n_act),
    .a_act      (a_act),
    .sel_act    (sel_act),
    .r_act      (r_act)
);

// File: tb/tb_pswallow_div.sv
// Bench for pswallow_div: behavioural period model compared every clock.
module tb_pswallow_div;
    logic        clk_vco = 1'b0;
    logic        clk_ref = 1'b0;
    logic        rst_n   = 1'b0;
    logic [10:0] n_set   = 11'd20;
    logic [6:0]  a_set   = 7'd5;
    logic        narrow_sel = 1'b1;
    logic [13:0] r_set   = 14'd8;
    logic        fp, fr, ratio_clamp;

    int    checks = 0;
    int    errors = 0;
    int    cyc    = 0;
    bit    ref_done = 1'b0;
    bit    all_done = 1'b0;
    string fp_tag = "R8";
    string fr_tag = "R8";

    // model state
    int m_cnt = 0, m_total = 0, r_cnt = 0, r_total = 0;
    bit m_fp = 1'b0, m_clamp = 1'b0, m_fr = 1'b0;

    pswallow_div dut (
        .clk_vco(clk_vco), .clk_ref(clk_ref), .rst_n(rst_n),
        .n_set(n_set), .a_set(a_set), .narrow_sel(narrow_sel), .r_set(r_set),
        .fp(fp), .fr(fr), .ratio_clamp(ratio_clamp)
    );

    always #2 clk_vco = ~clk_vco;
    initial begin
        #1;
        forever #4 clk_ref = ~clk_ref;
    end

    function automatic int period_of(int n, int a, bit sel);
        int ae = (a >= n) ? n - 1 : a;
        return (sel ? 32 : 64) * n + ae;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Feedback model: counts fast cycles, pulses after the computed period.
    always @(posedge clk_vco) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_fp = 1'b0;
            m_total = period_of(int'(n_set), int'(a_set), narrow_sel);
            m_clamp = (a_set >= n_set);
        end else begin
            m_cnt++;
            if (m_cnt == m_total) begin
                m_fp = 1'b1; m_cnt = 0;
                m_total = period_of(int'(n_set), int'(a_set), narrow_sel);
                m_clamp = (a_set >= n_set);
            end else begin
                m_fp = 1'b0;
            end
        end
    end

    // Reference model.
    always @(posedge clk_ref) begin
        if (!rst_n) begin
            r_cnt = 0; m_fr = 1'b0; r_total = int'(r_set);
        end else begin
            r_cnt++;
            if (r_cnt == r_total) begin
                m_fr = 1'b1; r_cnt = 0; r_total = int'(r_set);
            end else begin
                m_fr = 1'b0;
            end
        end
    end

    // Per-cycle comparison away from the active edges.
    always @(negedge clk_vco) begin
        if (!all_done) begin
            check(fp_tag, int'(fp), int'(m_fp));
            check("R7 ratio_clamp", int'(ratio_clamp), int'(m_clamp));
        end
    end
    always @(negedge clk_ref) begin
        if (!all_done) check(fr_tag, int'(fr), int'(m_fr));
    end

    // Watchdog.
    always @(posedge clk_vco) begin
        if (cyc > 190000 && !all_done) begin
            all_done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wait_fp(int k);
        repeat (k) begin
            @(negedge clk_vco);
            while (!m_fp) @(negedge clk_vco);
        end
    endtask

    task automatic wait_fr(int k);
        repeat (k) begin
            @(negedge clk_ref);
            while (!m_fr) @(negedge clk_ref);
        end
    endtask

    // Reference-side scenarios.
    initial begin
        @(posedge rst_n);
        fr_tag = "R8 first fr";
        wait_fr(1);
        fr_tag = "R4 R=8";
        wait_fr(2);
        @(negedge clk_ref); r_set = 14'd9;
        wait_fr(3);
        fr_tag = "R6 mid-period r_set change";
        wait_fr(1);
        repeat (3) @(negedge clk_ref); r_set = 14'd12;
        repeat (2) @(negedge clk_ref); r_set = 14'd20;
        wait_fr(3);
        repeat (5) @(negedge clk_ref); r_set = 14'd8;
        wait_fr(3);
        fr_tag = "R4 R=16383";
        @(negedge clk_ref); r_set = 14'd16383;
        wait_fr(3);
        ref_done = 1'b1;
    end

    // Feedback-side scenarios.
    initial begin
        repeat (6) @(negedge clk_vco);
        check("R8 reset fp", int'(fp), 0);
        check("R8 reset ratio_clamp", int'(ratio_clamp), 0);
        rst_n = 1'b1;
        fp_tag = "R8 first period";
        wait_fp(1);

        fp_tag = "R1 N=20 A=5 P=32";
        wait_fp(2);

        fp_tag = "R2 P=64";
        narrow_sel = 1'b0;
        wait_fp(3);

        fp_tag = "R3 A=0";
        narrow_sel = 1'b1; n_set = 11'd16; a_set = 7'd0;
        wait_fp(3);

        fp_tag = "R5 mid-period changes";
        n_set = 11'd24; a_set = 7'd3;
        wait_fp(1);
        for (int i = 0; i < 6; i++) begin
            repeat (137) @(negedge clk_vco);
            n_set = 11'(17 + i * 7);
            a_set = 7'(i * 3);
            narrow_sel = i[0];
        end
        wait_fp(2);

        fp_tag = "R7 clamp A>N";
        narrow_sel = 1'b1; n_set = 11'd30; a_set = 7'd40;
        wait_fp(3);
        check("R7 flag while clamped", int'(ratio_clamp), 1);
        fp_tag = "R7 clamp A=N";
        n_set = 11'd20; a_set = 7'd20;
        wait_fp(2);
        fp_tag = "R7 clamp A=63 N=16";
        n_set = 11'd16; a_set = 7'd63;
        wait_fp(2);
        fp_tag = "R7 valid again";
        n_set = 11'd30; a_set = 7'd10;
        wait_fp(3);
        check("R7 flag cleared", int'(ratio_clamp), 0);

        fp_tag = "R9 N=2047 A=63";
        n_set = 11'd2047; a_set = 7'd63;
        wait_fp(2);
        fp_tag = "R9 N=16 A=15 P=64";
        narrow_sel = 1'b0; n_set = 11'd16; a_set = 7'd15;
        wait_fp(3);

        while (!ref_done) @(negedge clk_vco);
        all_done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule